// File: doc/BRIEF.md
# Register-Offset Block Transfer Sequencer

This block sequences complete block read and block write transactions toward a device on a two-wire serial bus. It sits above a byte engine that owns all bit timing. The sequencer only decides which byte-level command comes next: a byte write with or without a leading START, a byte read with or without acknowledge, or a STOP. A requester supplies a read/write select, an 8-bit device code whose least significant bit is zero, a one-byte register offset and a length. Write data is pulled from a byte stream with a valid/ready handshake. Read data is pushed out as a stream of one-cycle strobes.

For a normal read, the sequencer writes the device code and then the offset. It then keeps the bus idle for a configurable gap and issues a repeated START with the read form of the device code. A legacy mode targets devices that take the offset itself as the address byte. Writes are split into short bursts. After each burst the sequencer polls the device with read-form address bytes until one is acknowledged. It then reads and discards a single byte before starting the next burst. Any refused byte ends the transaction with a STOP and an error.

Top module: `blk_xfer_seq`

## Requirements
- R1: A request is accepted in a cycle with `req_valid_i` and `req_ready_o` both high. A request of length zero gives a `done_o` pulse with `err_o` low and issues no engine command.
- R2: A normal read issues three commands in this order: write-with-START of `dev`, write of the offset without START, and write-with-START of `dev|1`. At least GAP_CYCLES cycles pass between the completion of the offset byte and the issue of the repeated START. No STOP is issued between them.
- R3: A legacy read issues one write-with-START of `{off[6:0],1}` and then goes straight to the data reads.
- R4: Each read data byte appears on `rd_data_o` with a one-cycle `rd_valid_o`. Every byte read except the last is acknowledged. The last byte is not acknowledged and is followed by a STOP, and then `done_o` rises with `err_o` low.
- R5: A NACK on any address or offset byte of a read, or on the address byte of a write, is followed by a single STOP. The transaction then ends with `done_o` and `err_o` high, and no further command is issued.
- R6: A normal write is split into bursts of at most BURST bytes. Each burst issues write-with-START of `dev`, then the current offset, then its data bytes, then a STOP. The offset of each burst is the starting offset plus the number of bytes already written, modulo 256.
- R7: In legacy mode a write burst opens with a single write-with-START of `{off[6:0],0}`, with no separate offset byte.
- R8: After each burst STOP, the sequencer issues write-with-START of `dev|1`. Each NACK of that poll is followed by a STOP and a new poll. After POLL_MAX refused polls in one burst, the transaction ends with `err_o` high.
- R9: An acknowledged poll is followed by one read without acknowledge and a STOP. The byte from that read is never presented on `rd_valid_o`. The next burst or completion follows.
- R10: A NACK on a write data byte is followed by a STOP and ends the transaction with `err_o` high.
- R11: `eng_valid_o` is a one-cycle pulse. No new command is issued before the engine has signalled `eng_done_i` for the previous one. Op codes are 0 for a byte write, 1 for a byte read and 2 for STOP.
- R12: `done_o` is a one-cycle pulse. `err_o` takes its final value in that cycle and keeps it until the next request is accepted. `req_ready_o` is high only when no transaction is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Transaction request |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| req_read_i | input | 1 | 1 for block read, 0 for block write |
| req_legacy_i | input | 1 | Offset forms the address byte |
| req_dev_i | input | 8 | Device code, LSB zero |
| req_off_i | input | 8 | Starting register offset |
| req_len_i | input | LEN_W | Number of data bytes |
| wr_data_i | input | 8 | Write data byte |
| wr_valid_i | input | 1 | Write data available |
| wr_ready_o | output | 1 | Sequencer takes a write byte |
| rd_data_o | output | 8 | Read data byte |
| rd_valid_o | output | 1 | Read data strobe |
| done_o | output | 1 | Transaction finished |
| err_o | output | 1 | Transaction failed |
| eng_valid_o | output | 1 | Command to byte engine |
| eng_op_o | output | 2 | 0 write byte, 1 read byte, 2 STOP |
| eng_start_o | output | 1 | Prefix START on a byte write |
| eng_ack_o | output | 1 | Acknowledge after a byte read |
| eng_data_o | output | 8 | Byte to write |
| eng_done_i | input | 1 | Engine finished the command |
| eng_nack_i | input | 1 | Written byte was refused |
| eng_data_i | input | 8 | Byte read by the engine |

## Verification
A wrong phase or a wrong offset register shows up on the very next engine command. The bench therefore compares the full command stream of every transaction, field by field. A broken burst or remaining-length count shows as a misplaced STOP or poll within one burst. A stuck poll counter either ends a write early with an error or never ends it, and the exhaustion test catches this after exactly POLL_MAX attempts. Read-path faults show as a missing, extra or misvalued `rd_valid_o` strobe, or as a wrong acknowledge on the last read.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
  typedef enum logic [1:0] {
    OP_WR   = 2'd0,
    OP_RD   = 2'd1,
    OP_STOP = 2'd2
  } eng_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE, ST_WAIT, ST_GAP, ST_FETCH, ST_DONE
  } st_e;

  typedef enum logic [3:0] {
    PH_ADDR,   // first address byte of a read or burst
    PH_OFF,    // register offset
    PH_DEVR,   // repeated start, read form
    PH_RDATA,  // read data byte
    PH_WDATA,  // write data byte
    PH_POLL,   // completion poll
    PH_DUMMY,  // discarded read after poll ack
    PH_SFAIL,  // stop on failure
    PH_SEND,   // stop after last read
    PH_SBURST, // stop after burst
    PH_SPOLL,  // stop after refused poll
    PH_SDUMMY  // stop after discarded read
  } ph_e;
endpackage

// File: rtl/bxs_gap_timer.sv
module bxs_gap_timer #(
  parameter int unsigned CYC = 12000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  if (CYC == 0) begin : g_nogap
    logic d_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) d_q <= 1'b0;
      else         d_q <= start_i;
    assign done_o = d_q;
  end else begin : g_cnt
    localparam int CW = $clog2(CYC + 1);
    logic [CW-1:0] cnt_q;
    logic          run_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else if (start_i) begin
        run_q <= 1'b1;
        cnt_q <= CW'(CYC - 1);
      end else if (run_q) begin
        if (cnt_q == '0) run_q <= 1'b0;
        else             cnt_q <= cnt_q - 1'b1;
      end
    end
    assign done_o = run_q && (cnt_q == '0);
  end
endmodule

// File: rtl/bxs_poll_ctr.sv
module bxs_poll_ctr #(
  parameter int unsigned MAXN = 100,
  localparam int CW = $clog2(MAXN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o,
  output logic          exh_o
);
  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clr_i)                       cnt_q <= '0;
    else if (inc_i && cnt_q != CW'(MAXN)) cnt_q <= cnt_q + 1'b1;
  end
  assign cnt_o = cnt_q;
  assign exh_o = (cnt_q == CW'(MAXN));
endmodule

// File: rtl/bxs_ctrl.sv
module bxs_ctrl
  import bxs_pkg::*;
#(
  parameter int unsigned LEN_W = 8,
  parameter int unsigned BURST = 4,
  localparam int BRW = $clog2(BURST + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_read_i,
  input  logic             req_legacy_i,
  input  logic [7:0]       req_dev_i,
  input  logic [7:0]       req_off_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic [7:0]       wr_data_i,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  output logic             done_o,
  output logic             err_o,
  output logic             eng_valid_o,
  output logic [1:0]       eng_op_o,
  output logic             eng_start_o,
  output logic             eng_ack_o,
  output logic [7:0]       eng_data_o,
  input  logic             eng_done_i,
  input  logic             eng_nack_i,
  input  logic [7:0]       eng_data_i,
  output logic             gap_start_o,
  input  logic             gap_done_i,
  output logic             poll_clr_o,
  output logic             poll_inc_o,
  input  logic             poll_exh_i
);
  st_e  st_q, st_d;
  ph_e  ph_q, ph_d;

  logic             rd_q, leg_q, err_q, rdv_q;
  logic [7:0]       dev_q, off_q, wbyte_q, rdat_q;
  logic [LEN_W-1:0] len_q;
  logic [BRW-1:0]   brem_q;

  logic accept, fin_err, rd_strobe, wr_take, byte_done, burst_next;

  function automatic logic [BRW-1:0] burst_len(input logic [LEN_W-1:0] n);
    return (n >= LEN_W'(BURST)) ? BRW'(BURST) : BRW'(n);
  endfunction

  always_comb begin
    st_d        = st_q;
    ph_d        = ph_q;
    accept      = 1'b0;
    fin_err     = 1'b0;
    rd_strobe   = 1'b0;
    wr_take     = 1'b0;
    byte_done   = 1'b0;
    burst_next  = 1'b0;
    gap_start_o = 1'b0;
    poll_clr_o  = 1'b0;
    poll_inc_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) begin
        accept = 1'b1;
        if (req_len_i == '0) st_d = ST_DONE;
        else begin
          st_d       = ST_ISSUE;
          ph_d       = PH_ADDR;
          poll_clr_o = 1'b1;
        end
      end
      ST_ISSUE: st_d = ST_WAIT;
      ST_GAP: if (gap_done_i) begin
        st_d = ST_ISSUE;
        ph_d = PH_DEVR;
      end
      ST_FETCH: if (wr_valid_i) begin
        wr_take = 1'b1;
        st_d    = ST_ISSUE;
      end
      ST_DONE: st_d = ST_IDLE;
      ST_WAIT: if (eng_done_i) begin
        st_d = ST_ISSUE;
        unique case (ph_q)
          PH_ADDR:
            if (eng_nack_i)  ph_d = PH_SFAIL;
            else if (rd_q)   ph_d = leg_q ? PH_RDATA : PH_OFF;
            else if (leg_q) begin
              ph_d = PH_WDATA;
              st_d = ST_FETCH;
            end else         ph_d = PH_OFF;
          PH_OFF:
            if (eng_nack_i) ph_d = PH_SFAIL;
            else if (rd_q) begin
              st_d        = ST_GAP;
              gap_start_o = 1'b1;
            end else begin
              ph_d = PH_WDATA;
              st_d = ST_FETCH;
            end
          PH_DEVR: ph_d = eng_nack_i ? PH_SFAIL : PH_RDATA;
          PH_RDATA: begin
            rd_strobe = 1'b1;
            if (len_q == LEN_W'(1)) ph_d = PH_SEND;
          end
          PH_WDATA:
            if (eng_nack_i) ph_d = PH_SFAIL;
            else begin
              byte_done = 1'b1;
              if (brem_q == BRW'(1)) ph_d = PH_SBURST;
              else st_d = ST_FETCH;
            end
          PH_SBURST: begin
            ph_d       = PH_POLL;
            poll_clr_o = 1'b1;
          end
          PH_POLL:
            if (eng_nack_i) begin
              poll_inc_o = 1'b1;
              ph_d       = PH_SPOLL;
            end else ph_d = PH_DUMMY;
          PH_SPOLL:
            if (poll_exh_i) begin
              st_d    = ST_DONE;
              fin_err = 1'b1;
            end else ph_d = PH_POLL;
          PH_DUMMY: ph_d = PH_SDUMMY;
          PH_SDUMMY:
            if (len_q == '0) st_d = ST_DONE;
            else begin
              ph_d       = PH_ADDR;
              burst_next = 1'b1;
            end
          PH_SEND: st_d = ST_DONE;
          default: begin
            st_d    = ST_DONE;
            fin_err = 1'b1;
          end
        endcase
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ph_q    <= PH_ADDR;
      rd_q    <= 1'b0;
      leg_q   <= 1'b0;
      err_q   <= 1'b0;
      rdv_q   <= 1'b0;
      dev_q   <= '0;
      off_q   <= '0;
      wbyte_q <= '0;
      rdat_q  <= '0;
      len_q   <= '0;
      brem_q  <= '0;
    end else begin
      st_q  <= st_d;
      ph_q  <= ph_d;
      rdv_q <= rd_strobe;
      if (accept) begin
        rd_q   <= req_read_i;
        leg_q  <= req_legacy_i;
        dev_q  <= req_dev_i;
        off_q  <= req_off_i;
        len_q  <= req_len_i;
        brem_q <= burst_len(req_len_i);
        err_q  <= 1'b0;
      end else if (fin_err) begin
        err_q <= 1'b1;
      end
      if (wr_take) wbyte_q <= wr_data_i;
      if (byte_done) begin
        len_q  <= len_q - 1'b1;
        brem_q <= brem_q - 1'b1;
        off_q  <= off_q + 1'b1;
      end
      if (rd_strobe) begin
        len_q  <= len_q - 1'b1;
        rdat_q <= eng_data_i;
      end
      if (burst_next) brem_q <= burst_len(len_q);
    end
  end

  // command presented to the byte engine for the current phase
  always_comb begin
    eng_op_o    = OP_STOP;
    eng_start_o = 1'b0;
    eng_ack_o   = 1'b0;
    eng_data_o  = '0;
    unique case (ph_q)
      PH_ADDR: begin
        eng_op_o    = OP_WR;
        eng_start_o = 1'b1;
        eng_data_o  = leg_q ? {off_q[6:0], rd_q} : dev_q;
      end
      PH_OFF: begin
        eng_op_o   = OP_WR;
        eng_data_o = off_q;
      end
      PH_DEVR, PH_POLL: begin
        eng_op_o    = OP_WR;
        eng_start_o = 1'b1;
        eng_data_o  = dev_q | 8'h01;
      end
      PH_RDATA: begin
        eng_op_o  = OP_RD;
        eng_ack_o = (len_q != LEN_W'(1));
      end
      PH_WDATA: begin
        eng_op_o   = OP_WR;
        eng_data_o = wbyte_q;
      end
      PH_DUMMY: eng_op_o = OP_RD;
      default:  eng_op_o = OP_STOP;
    endcase
  end

  assign eng_valid_o = (st_q == ST_ISSUE);
  assign req_ready_o = (st_q == ST_IDLE);
  assign wr_ready_o  = (st_q == ST_FETCH);
  assign done_o      = (st_q == ST_DONE);
  assign err_o       = err_q;
  assign rd_valid_o  = rdv_q;
  assign rd_data_o   = rdat_q;
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned BURST      = 4,
  parameter int unsigned POLL_MAX   = 100,
  parameter int unsigned GAP_CYCLES = 12000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_read_i,
  input  logic             req_legacy_i,
  input  logic [7:0]       req_dev_i,
  input  logic [7:0]       req_off_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic [7:0]       wr_data_i,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  output logic             done_o,
  output logic             err_o,
  output logic             eng_valid_o,
  output logic [1:0]       eng_op_o,
  output logic             eng_start_o,
  output logic             eng_ack_o,
  output logic [7:0]       eng_data_o,
  input  logic             eng_done_i,
  input  logic             eng_nack_i,
  input  logic [7:0]       eng_data_i
);
  localparam int PCW = $clog2(POLL_MAX + 1);

  logic           gap_start, gap_done, poll_clr, poll_inc, poll_exh;
  logic [PCW-1:0] poll_cnt;

  bxs_ctrl #(.LEN_W(LEN_W), .BURST(BURST)) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_read_i, .req_legacy_i,
    .req_dev_i, .req_off_i, .req_len_i,
    .wr_data_i, .wr_valid_i, .wr_ready_o,
    .rd_data_o, .rd_valid_o, .done_o, .err_o,
    .eng_valid_o, .eng_op_o, .eng_start_o, .eng_ack_o, .eng_data_o,
    .eng_done_i, .eng_nack_i, .eng_data_i,
    .gap_start_o(gap_start), .gap_done_i(gap_done),
    .poll_clr_o(poll_clr), .poll_inc_o(poll_inc), .poll_exh_i(poll_exh)
  );

  bxs_gap_timer #(.CYC(GAP_CYCLES)) u_gap (
    .clk_i, .rst_ni, .start_i(gap_start), .done_o(gap_done)
  );

  bxs_poll_ctr #(.MAXN(POLL_MAX)) u_poll (
    .clk_i, .rst_ni, .clr_i(poll_clr), .inc_i(poll_inc),
    .cnt_o(poll_cnt), .exh_o(poll_exh)
  );
endmodule

// File: rtl/bxs_chk.sv
module bxs_chk #(
  parameter int unsigned POLL_MAX = 100,
  localparam int PCW = $clog2(POLL_MAX + 1)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_ready_o,
  input logic           wr_ready_o,
  input logic           rd_valid_o,
  input logic           done_o,
  input logic           err_o,
  input logic           eng_valid_o,
  input logic           eng_done_i,
  input logic [PCW-1:0] poll_cnt
);
  logic out_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          out_q <= 1'b0;
    else if (eng_valid_o) out_q <= 1'b1;
    else if (eng_done_i)  out_q <= 1'b0;

  assert_cmd_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_valid_o |=> !eng_valid_o);
  assert_one_outstanding_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_valid_o |-> !out_q);
  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_err_at_done_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o);
  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!wr_ready_o && !eng_valid_o));
  assert_rd_follows_engine_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(eng_done_i));
  assert_poll_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_cnt <= PCW'(POLL_MAX));
endmodule

bind blk_xfer_seq bxs_chk #(.POLL_MAX(POLL_MAX)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o),
  .wr_ready_o(wr_ready_o), .rd_valid_o(rd_valid_o), .done_o(done_o),
  .err_o(err_o), .eng_valid_o(eng_valid_o), .eng_done_i(eng_done_i),
  .poll_cnt(poll_cnt)
);

// File: tb/sim_blk_xfer_seq.sv
`timescale 1ns/1ps
module sim_blk_xfer_seq;
  localparam int GAP = 16;
  localparam int LAT = 3;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       req_valid = 1'b0, req_read = 1'b0, req_legacy = 1'b0;
  logic [7:0] req_dev = '0, req_off = '0, wr_data;
  logic [7:0] req_len = '0;
  logic       req_ready, wr_ready, rd_valid, done, err;
  logic [7:0] rd_data, eng_data, eng_rdata = '0;
  logic       eng_valid, eng_start, eng_ack;
  logic [1:0] eng_op;
  logic       eng_done = 1'b0, eng_nack = 1'b0;

  int errors = 0, checks = 0, cyc = 0;
  int log_n, exp_n, rcnt, rd_served, done_cnt, wr_idx, nack_idx, poll_fail;
  bit tst_wr, done_err;
  logic [7:0]  cur_dev;
  logic [11:0] log_key [0:511];
  int          log_t   [0:511];
  logic [11:0] exp_key [0:511];
  logic [7:0]  rbuf    [0:63];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign wr_data = 8'hC0 + 8'(wr_idx);

  blk_xfer_seq #(.LEN_W(8), .BURST(4), .POLL_MAX(100), .GAP_CYCLES(GAP)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_read_i(req_read),
    .req_legacy_i(req_legacy), .req_dev_i(req_dev), .req_off_i(req_off),
    .req_len_i(req_len), .wr_data_i(wr_data), .wr_valid_i(1'b1),
    .wr_ready_o(wr_ready), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .done_o(done), .err_o(err), .eng_valid_o(eng_valid), .eng_op_o(eng_op),
    .eng_start_o(eng_start), .eng_ack_o(eng_ack), .eng_data_o(eng_data),
    .eng_done_i(eng_done), .eng_nack_i(eng_nack), .eng_data_i(eng_rdata)
  );

  function automatic logic [11:0] norm(input logic [1:0] op, input logic s,
                                       input logic a, input logic [7:0] d);
    return {op, (op == 2'd0) ? s : 1'b0, (op == 2'd1) ? a : 1'b0,
            (op == 2'd0) ? d : 8'h00};
  endfunction

  // byte engine model
  initial forever begin
    @(negedge clk);
    while (eng_valid) begin
      logic [11:0] k;
      k = norm(eng_op, eng_start, eng_ack, eng_data);
      if (log_n < 512) begin
        log_key[log_n] = k;
        log_t[log_n]   = cyc;
      end
      repeat (LAT - 1) @(negedge clk);
      eng_nack  = (log_n == nack_idx);
      if (tst_wr && k == {2'd0, 1'b1, 1'b0, cur_dev | 8'h01} && poll_fail > 0) begin
        eng_nack  = 1'b1;
        poll_fail = poll_fail - 1;
      end
      eng_rdata = 8'hA0 + 8'(rd_served);
      if (k[11:10] == 2'd1) rd_served++;
      log_n++;
      eng_done = 1'b1;
      @(negedge clk);
      eng_done = 1'b0;
      eng_nack = 1'b0;
    end
  end

  // write stream and output monitor
  initial forever begin
    @(negedge clk);
    if (wr_ready) begin
      @(posedge clk);
      #1 wr_idx++;
    end
  end
  initial forever begin
    @(negedge clk);
    if (rd_valid && rcnt < 64) rbuf[rcnt++] = rd_data;
    if (done) begin
      done_cnt++;
      done_err = err;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic ew(input bit s, input logic [7:0] d);
    exp_key[exp_n++] = norm(2'd0, s, 1'b0, d);
  endtask
  task automatic er(input bit a);
    exp_key[exp_n++] = norm(2'd1, 1'b0, a, 8'h00);
  endtask
  task automatic es();
    exp_key[exp_n++] = norm(2'd2, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic check_log(input string req);
    int bad;
    bad = -1;
    if (log_n != exp_n) chk(1'b0, req, "command count", log_n, exp_n);
    else begin
      for (int i = 0; i < exp_n; i++)
        if (bad < 0 && log_key[i] != exp_key[i]) bad = i;
      chk(bad < 0, req, "command stream", (bad < 0) ? 0 : int'(log_key[bad]),
          (bad < 0) ? 0 : int'(exp_key[bad]));
    end
  endtask

  task automatic run(input bit rd, input bit leg, input logic [7:0] dev,
                     input logic [7:0] off, input int len);
    log_n = 0; exp_n = 0; rcnt = 0; rd_served = 0; done_cnt = 0; wr_idx = 0;
    cur_dev = dev; tst_wr = !rd;
    @(negedge clk);
    req_read = rd; req_legacy = leg; req_dev = dev; req_off = off;
    req_len = 8'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (done_cnt == 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R12", "idle ready after reset", req_ready, 1);
    chk(eng_valid == 1'b0 && done == 1'b0, "R11", "quiet after reset",
        {eng_valid, done}, 0);
  endtask

  task automatic t_zero_len();
    nack_idx = -1; poll_fail = 0;
    run(1'b0, 1'b0, 8'h50, 8'h00, 0);
    chk(done_cnt == 1 && !done_err, "R1", "zero length done", {done_cnt, done_err}, 2);
    chk(log_n == 0, "R1", "zero length commands", log_n, 0);
  endtask

  task automatic t_read();
    nack_idx = -1; poll_fail = 0;
    run(1'b1, 1'b0, 8'hA0, 8'h10, 3);
    ew(1, 8'hA0); ew(0, 8'h10); ew(1, 8'hA1); er(1); er(1); er(0); es();
    check_log("R2");
    chk(log_n > 2 && (log_t[2] - log_t[1]) >= LAT + GAP, "R2", "repeated start gap",
        log_t[2] - log_t[1], LAT + GAP);
    chk(rcnt == 3 && rbuf[0] == 8'hA0 && rbuf[1] == 8'hA1 && rbuf[2] == 8'hA2,
        "R4", "read data stream", rcnt, 3);
    chk(!done_err, "R4", "read error flag", done_err, 0);
  endtask

  task automatic t_legacy_read();
    nack_idx = -1; poll_fail = 0;
    run(1'b1, 1'b1, 8'hA0, 8'h45, 2);
    ew(1, 8'h8B); er(1); er(0); es();
    check_log("R3");
    chk(rcnt == 2 && rbuf[0] == 8'hA0 && rbuf[1] == 8'hA1, "R4", "legacy read data",
        rcnt, 2);
  endtask

  task automatic t_read_off_nack();
    nack_idx = 1; poll_fail = 0;
    run(1'b1, 1'b0, 8'hA0, 8'h22, 2);
    ew(1, 8'hA0); ew(0, 8'h22); es();
    check_log("R5");
    chk(done_err && rcnt == 0, "R5", "offset nack error, no data", {done_err, rcnt[3:0]}, 16);
    repeat (5) @(negedge clk);
    chk(err == 1'b1, "R12", "error held after done", err, 1);
  endtask

  task automatic t_write_bursts();
    nack_idx = -1; poll_fail = 0;
    run(1'b0, 1'b0, 8'h50, 8'h20, 6);
    ew(1, 8'h50); ew(0, 8'h20);
    for (int i = 0; i < 4; i++) ew(0, 8'hC0 + 8'(i));
    es(); ew(1, 8'h51); er(0); es();
    ew(1, 8'h50); ew(0, 8'h24); ew(0, 8'hC4); ew(0, 8'hC5);
    es(); ew(1, 8'h51); er(0); es();
    check_log("R6");
    chk(rcnt == 0, "R9", "discarded byte not presented", rcnt, 0);
    chk(!done_err && err == 1'b0, "R12", "error cleared by new request", err, 0);
  endtask

  task automatic t_legacy_write_poll();
    nack_idx = -1; poll_fail = 2;
    run(1'b0, 1'b1, 8'h50, 8'h33, 2);
    ew(1, 8'h66); ew(0, 8'hC0); ew(0, 8'hC1); es();
    ew(1, 8'h51); es(); ew(1, 8'h51); es(); ew(1, 8'h51); er(0); es();
    check_log("R7");
    chk(!done_err && rcnt == 0, "R8", "poll retried then success", done_err, 0);
  endtask

  task automatic t_poll_exhaust();
    nack_idx = -1; poll_fail = 1000;
    run(1'b0, 1'b0, 8'h50, 8'h07, 1);
    ew(1, 8'h50); ew(0, 8'h07); ew(0, 8'hC0); es();
    for (int i = 0; i < 100; i++) begin
      ew(1, 8'h51); es();
    end
    check_log("R8");
    chk(done_err, "R8", "poll exhaustion error", done_err, 1);
  endtask

  task automatic t_data_nack();
    nack_idx = 3; poll_fail = 0;
    run(1'b0, 1'b0, 8'h50, 8'h40, 3);
    ew(1, 8'h50); ew(0, 8'h40); ew(0, 8'hC0); ew(0, 8'hC1); es();
    check_log("R10");
    chk(done_err, "R10", "data nack error", done_err, 1);
  endtask

  task automatic t_wr_addr_nack();
    nack_idx = 0; poll_fail = 0;
    run(1'b0, 1'b0, 8'h50, 8'h40, 3);
    ew(1, 8'h50); es();
    check_log("R5");
    chk(done_err, "R5", "write address nack error", done_err, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    nack_idx = -1; poll_fail = 0; log_n = 0; rd_served = 0; rcnt = 0;
    done_cnt = 0; wr_idx = 0; tst_wr = 0; cur_dev = '0; done_err = 0; exp_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_len();
    t_read();
    t_legacy_read();
    t_read_off_nack();
    t_write_bursts();
    t_legacy_write_poll();
    t_poll_exhaust();
    t_data_nack();
    t_wr_addr_nack();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule